// File: doc/BRIEF.md
# Operand Effective Address Sequencer

This unit takes one 6-bit operand specifier and turns it into either a register reference or a memory effective address. When the operand is a source, it also fetches the operand value. The specifier's upper three bits give the addressing mode and its lower three bits give the register number. Register 6 acts as the stack pointer and register 7 as the program counter.

The unit reads and writes an external bank of eight 16-bit registers. It drives a read-only, word-wide memory port with a request/ready handshake. Memory is byte addressed and little endian: the low byte of a word is at the even address. The unit applies the post-increment, pre-decrement and program-counter side effects itself.

The instruction decoder pulses `start` with the specifier, the operand size and the source/destination flag. It then waits for `done`. When `done` is high, `ea`, `reg_direct`, `op_data` and `illegal` are valid, and they hold until the next start. Because index modes fetch their extra word through the program counter, the same sequencing with register 7 gives immediate, absolute, PC-relative and PC-relative-deferred operands.

Top module: `opnd_ea_seq`

## Requirements
- R1: Mode 0 makes no memory access and writes no register. It sets `reg_direct`, returns the register number in `ea`, and returns the register value in `op_data` (for a byte operation, the low byte zero-extended).
- R2: Mode 1 uses the register contents as `ea` and leaves every register unchanged.
- R3: Mode 2 uses the old register contents as `ea`, then adds the step to the register. With register 7 this yields an immediate operand taken from the word after the instruction, and the PC advances by 2.
- R4: Mode 4 subtracts the step from the register first, then uses the new value as `ea`.
- R5: The step is 1 only for byte operations in modes 2 and 4 on registers 0 to 5. In every other case it is 2, including modes 3 and 5 and registers 6 and 7.
- R6: Modes 6 and 7 read an extra word X at the current PC and advance the PC by 2. They form the address as register plus X. With register 7 the base is the PC after it has advanced.
- R7: The deferred modes 3, 5 and 7 first obtain an address as modes 2, 4 and 6 do, always with step 2. They then read the word at that address, with bit 0 forced to 0, and use that word as the final `ea`.
- R8: A source operand in modes 1 to 7 makes one final memory read of the word at `ea` with bit 0 cleared. A word operation returns the whole word. A byte operation returns the high byte when `ea[0]` is 1 and the low byte when it is 0, zero-extended.
- R9: For a destination operand (`is_dst`=1), the unit skips the final data read and returns `op_data` = 0. Address calculation and register side effects are the same as for a source operand.
- R10: Modes 4 and 5 with register 7 set `illegal`, write no register and make no memory access.
- R11: Once raised, `mem_req` stays high with a stable `mem_addr` until `mem_ready`. Every `mem_addr` is even.
- R12: After reset `done`, `mem_req`, `illegal` and `rf_we` are low. Each accepted start produces exactly one single-cycle `done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin resolving `spec`; honoured only when idle |
| spec | input | 6 | Mode in bits 5:3, register number in bits 2:0 |
| byte_op | input | 1 | 1 = byte operand, 0 = word operand |
| is_dst | input | 1 | 1 = destination operand (no final data read) |
| rf_rsel | output | 3 | Register read select (the specifier's register) |
| rf_rdata | input | 16 | Contents of the selected register |
| rf_pc | input | 16 | Current contents of register 7 |
| rf_we | output | 1 | Register write enable |
| rf_wsel | output | 3 | Register write select |
| rf_wdata | output | 16 | Register write data |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 16 | Memory byte address (always even) |
| mem_ready | input | 1 | Memory read complete; `mem_rdata` valid |
| mem_rdata | input | 16 | Memory read word |
| ea | output | 16 | Effective address, or register number when `reg_direct` |
| reg_direct | output | 1 | Operand is a register (mode 0) |
| op_data | output | 16 | Fetched operand value |
| illegal | output | 1 | Specifier cannot be used |
| done | output | 1 | Single-cycle completion pulse |

## Verification
The assertions assume that `start` comes only while the unit is idle. They also assume that the register bank presents a write on the next read. The bench meets both conditions: it raises `start` for one cycle only after it has seen the previous `done`. Its register model updates on the clock edge at which `rf_we` is sampled. The memory responder answers each request after a random delay of zero to two cycles, with a one-cycle `mem_ready`, so the handshake is exercised under both immediate and stalled replies. Register preloads keep the PC even, because instruction words sit at even addresses. All other registers take arbitrary values, so odd addresses reach the byte path.

// File: rtl/opnd_ea_seq.sv
module opnd_ea_seq #(
  parameter int DW = 16,
  parameter int RW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [5:0]    spec,
  input  logic          byte_op,
  input  logic          is_dst,
  output logic [RW-1:0] rf_rsel,
  input  logic [DW-1:0] rf_rdata,
  input  logic [DW-1:0] rf_pc,
  output logic          rf_we,
  output logic [RW-1:0] rf_wsel,
  output logic [DW-1:0] rf_wdata,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr,
  input  logic          mem_ready,
  input  logic [DW-1:0] mem_rdata,
  output logic [DW-1:0] ea,
  output logic          reg_direct,
  output logic [DW-1:0] op_data,
  output logic          illegal,
  output logic          done
);

  localparam logic [RW-1:0] PC_IDX = RW'(7);
  localparam logic [RW-1:0] SP_IDX = RW'(6);
  localparam int HB = DW / 2;

  typedef enum logic [2:0] {S_IDLE, S_CALC, S_IDX, S_PTR, S_DATA} st_t;
  st_t st;

  logic [2:0]    md;
  logic [RW-1:0] rn;
  logic          byt, dst;
  logic [DW-1:0] ea_q, data_q;
  logic          dir_q, ill_q, done_q;

  logic          pc_bad, small_step;
  logic [DW-1:0] step, incr, pc_next, idx_base, byte_sel;

  assign pc_bad     = (md == 3'd4 || md == 3'd5) && rn == PC_IDX;
  assign small_step = byt && (md == 3'd2 || md == 3'd4) && rn != SP_IDX && rn != PC_IDX;
  assign step       = small_step ? DW'(1) : DW'(2);
  assign incr       = (md == 3'd3 || md == 3'd5) ? DW'(2) : step;
  assign pc_next    = rf_pc + DW'(2);
  assign idx_base   = (rn == PC_IDX) ? pc_next : rf_rdata;
  assign byte_sel   = ea_q[0] ? {{(DW-HB){1'b0}}, mem_rdata[DW-1:HB]}
                              : {{(DW-HB){1'b0}}, mem_rdata[HB-1:0]};

  assign rf_rsel  = rn;
  assign rf_we    = (st == S_CALC && !pc_bad && (md == 3'd2 || md == 3'd3 || md == 3'd4 || md == 3'd5))
                 || (st == S_IDX && mem_ready);
  assign rf_wsel  = (st == S_IDX) ? PC_IDX : rn;
  assign rf_wdata = (st == S_IDX) ? pc_next
                  : (md[2] ? rf_rdata - incr : rf_rdata + incr);

  assign mem_req  = (st == S_IDX) || (st == S_PTR) || (st == S_DATA);
  assign mem_addr = (st == S_IDX) ? {rf_pc[DW-1:1], 1'b0} : {ea_q[DW-1:1], 1'b0};

  assign ea         = ea_q;
  assign op_data    = data_q;
  assign reg_direct = dir_q;
  assign illegal    = ill_q;
  assign done       = done_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      md     <= '0;
      rn     <= '0;
      byt    <= 1'b0;
      dst    <= 1'b0;
      ea_q   <= '0;
      data_q <= '0;
      dir_q  <= 1'b0;
      ill_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          md     <= spec[5:3];
          rn     <= spec[RW-1:0];
          byt    <= byte_op;
          dst    <= is_dst;
          dir_q  <= 1'b0;
          ill_q  <= 1'b0;
          data_q <= '0;
          st     <= S_CALC;
        end
        S_CALC: begin
          case (md)
            3'd0: begin
              ea_q   <= DW'(rn);
              data_q <= byt ? {{(DW-HB){1'b0}}, rf_rdata[HB-1:0]} : rf_rdata;
              dir_q  <= 1'b1;
              done_q <= 1'b1;
              st     <= S_IDLE;
            end
            3'd1, 3'd2: begin
              ea_q <= rf_rdata;
              if (dst) begin done_q <= 1'b1; st <= S_IDLE; end
              else st <= S_DATA;
            end
            3'd3: begin
              ea_q <= rf_rdata;
              st   <= S_PTR;
            end
            3'd4: begin
              if (pc_bad) begin
                ill_q <= 1'b1; done_q <= 1'b1; st <= S_IDLE;
              end else begin
                ea_q <= rf_rdata - step;
                if (dst) begin done_q <= 1'b1; st <= S_IDLE; end
                else st <= S_DATA;
              end
            end
            3'd5: begin
              if (pc_bad) begin
                ill_q <= 1'b1; done_q <= 1'b1; st <= S_IDLE;
              end else begin
                ea_q <= rf_rdata - DW'(2);
                st   <= S_PTR;
              end
            end
            default: st <= S_IDX;
          endcase
        end
        S_IDX: if (mem_ready) begin
          ea_q <= idx_base + mem_rdata;
          if (md == 3'd7) st <= S_PTR;
          else if (dst) begin done_q <= 1'b1; st <= S_IDLE; end
          else st <= S_DATA;
        end
        S_PTR: if (mem_ready) begin
          ea_q <= mem_rdata;
          if (dst) begin done_q <= 1'b1; st <= S_IDLE; end
          else st <= S_DATA;
        end
        S_DATA: if (mem_ready) begin
          data_q <= byt ? byte_sel : mem_rdata;
          done_q <= 1'b1;
          st     <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr))); // R11
  AST_EVEN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !mem_addr[0]); // R11
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rf_we && rf_wsel == PC_IDX) |-> (rf_wdata == rf_pc + DW'(2))); // R6
  AST_ILL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && illegal) |-> ($past(!rf_we) && $past(!mem_req))); // R10
  AST_DIR_NOMEM: assert property (@(posedge clk) disable iff (!rst_n)
    (done && reg_direct) |-> ($past(!mem_req) && !illegal)); // R1

endmodule

// File: tb/sim_opnd_ea_seq.sv
module sim_opnd_ea_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        start = 1'b0, byte_op = 1'b0, is_dst = 1'b0;
  logic [5:0]  spec = '0;
  logic [2:0]  rf_rsel, rf_wsel;
  logic [15:0] rf_wdata, mem_addr, ea, op_data;
  logic        rf_we, mem_req, reg_direct, illegal, done;
  logic        mem_ready = 1'b0;
  logic [15:0] mem_rdata = '0;
  logic [15:0] r [8];

  int checks = 0, errors = 0, reads = 0, odd_addr = 0, dly = 0;

  opnd_ea_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .spec(spec), .byte_op(byte_op), .is_dst(is_dst),
    .rf_rsel(rf_rsel), .rf_rdata(r[rf_rsel]), .rf_pc(r[7]),
    .rf_we(rf_we), .rf_wsel(rf_wsel), .rf_wdata(rf_wdata),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .ea(ea), .reg_direct(reg_direct), .op_data(op_data), .illegal(illegal), .done(done)
  );

  function automatic logic [15:0] mword(input logic [15:0] a);
    logic [15:0] t;
    t = {a[15:1], 1'b0};
    return (t * 16'h9E37 + 16'h1234) ^ (t >> 3);
  endfunction

  always @(posedge clk) if (rf_we) r[rf_wsel] <= rf_wdata;

  always @(negedge clk) begin
    if (mem_ready) mem_ready = 1'b0;
    else if (mem_req) begin
      if (dly == 0) begin
        mem_ready = 1'b1;
        mem_rdata = mword(mem_addr);
        reads++;
        if (mem_addr[0]) odd_addr++;
        dly = int'($urandom % 3);
      end else dly--;
    end
  end

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] m, input logic [2:0] rn, input logic bo, input logic ds);
    logic [15:0] e [8];
    logic [15:0] x_ea, x_data, p, inc, st;
    logic x_ill, x_dir;
    int x_reads, r0, to;
    string tag;
    for (int i = 0; i < 8; i++) e[i] = r[i];
    x_ill = (m == 3'd4 || m == 3'd5) && rn == 3'd7;
    x_dir = (m == 3'd0);
    st = (bo && (m == 3'd2 || m == 3'd4) && rn < 3'd6) ? 16'd1 : 16'd2;
    inc = (m == 3'd3 || m == 3'd5) ? 16'd2 : st;
    x_reads = 0; x_data = 16'h0; x_ea = 16'h0;
    case (m)
      3'd0: tag = "R1";
      3'd1: tag = "R2";
      3'd2: tag = "R3";
      3'd4: tag = "R4";
      3'd6: tag = "R6";
      default: tag = "R7";
    endcase
    if (x_ill) tag = "R10";
    else if (bo && (m == 3'd2 || m == 3'd4)) tag = "R5";
    else if (ds) tag = "R9";
    else if (bo) tag = "R8";
    if (!x_ill) begin
      case (m)
        3'd0: begin x_ea = {13'b0, rn}; x_data = bo ? {8'h0, e[rn][7:0]} : e[rn]; end
        3'd1: x_ea = e[rn];
        3'd2: begin x_ea = e[rn]; e[rn] = e[rn] + inc; end
        3'd3: begin p = e[rn]; e[rn] = e[rn] + inc; x_ea = mword(p); x_reads++; end
        3'd4: begin e[rn] = e[rn] - inc; x_ea = e[rn]; end
        3'd5: begin e[rn] = e[rn] - inc; x_ea = mword(e[rn]); x_reads++; end
        default: begin
          p = mword(e[7]); e[7] = e[7] + 16'd2; x_reads++;
          x_ea = e[rn] + p;
          if (m == 3'd7) begin x_ea = mword(x_ea); x_reads++; end
        end
      endcase
      if (m != 3'd0 && !ds) begin
        x_reads++;
        x_data = bo ? (x_ea[0] ? {8'h0, mword(x_ea)[15:8]} : {8'h0, mword(x_ea)[7:0]}) : mword(x_ea);
      end
    end
    r0 = reads;
    spec = {m, rn}; byte_op = bo; is_dst = ds; start = 1'b1;
    @(negedge clk); start = 1'b0;
    to = 0;
    while (!done && to < 100) begin @(negedge clk); to++; end
    if (to >= 100) begin
      checks++; errors++;
      $display("FAIL R12 watchdog actual=no-done expected=done");
      return;
    end
    chk(tag, "ill", {15'b0, illegal}, {15'b0, x_ill});
    chk(x_ill ? "R10" : "R1", "dir", {15'b0, reg_direct}, {15'b0, x_dir});
    if (!x_ill) begin
      chk(tag, "ea", ea, x_ea);
      chk(ds ? "R9" : tag, "data", op_data, x_data);
    end
    chk(tag, "reads", 16'(reads - r0), 16'(x_reads));
    for (int i = 0; i < 8; i++) chk(tag, "reg", r[i], e[i]);
    @(negedge clk);
    chk("R12", "done_pulse", {15'b0, done}, 16'h0);
  endtask

  task automatic preload();
    for (int i = 0; i < 7; i++) r[i] = 16'($urandom);
    r[7] = {15'($urandom), 1'b0};
  endtask

  initial begin
    void'($urandom(32'd2718));
    for (int i = 0; i < 8; i++) r[i] = 16'h0;
    repeat (3) @(negedge clk);
    chk("R12", "reset_done", {15'b0, done}, 16'h0);
    chk("R12", "reset_req", {15'b0, mem_req}, 16'h0);
    chk("R12", "reset_ill", {15'b0, illegal}, 16'h0);
    chk("R12", "reset_we", {15'b0, rf_we}, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 8; m++)
      for (int n = 0; n < 8; n++)
        for (int k = 0; k < 4; k++) begin
          preload();
          run(3'(m), 3'(n), k[0], k[1]);
        end
    // R5 corner: byte autoincrement on R0 step 1, on R6 step 2; odd address byte select R8
    r[0] = 16'h0101; run(3'd2, 3'd0, 1'b1, 1'b0);
    r[6] = 16'h0200; run(3'd2, 3'd6, 1'b1, 1'b0);
    r[3] = 16'h0000; run(3'd4, 3'd3, 1'b1, 1'b0);
    r[7] = 16'h0040; run(3'd2, 3'd7, 1'b0, 1'b0);
    r[7] = 16'hFFFE; run(3'd6, 3'd7, 1'b0, 1'b0);
    for (int i = 0; i < 300; i++) begin
      preload();
      run(3'($urandom), 3'($urandom), 1'($urandom), 1'($urandom));
    end
    chk("R11", "odd_addr", 16'(odd_addr), 16'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #900us;
    checks++; errors++;
    $display("FAIL R12 global watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule